// File: doc/BRIEF.md
# Single-Shot Comparator Status Bank

A bank of up to eight 64-bit status registers, one for each single-shot comparator unit of a trace unit. Each register holds two sticky flags: a match flag, set when its unit fires while the trace resources are active, and a pending flag, set when its unit fires while the resources are paused. The register also carries read-only capability bits, which are fixed for each unit by a parameter.

Software reaches the bank through a single access port. The port carries a valid strobe, a write strobe, the 4-bit CRm field of the register encoding and 64 bits of write data. An index whose encoding is malformed, or that names a unit that was not built, is reported as undefined and changes no state. Writes land only while the trace unit is idle. Read data is valid only in the idle or stable states. Every access gets its response on the cycle after it is presented.

The flag vectors are also exported continuously, so that neighbouring resource logic can use them without going through the access port.

Top module: `sscmp_status_bank`

## Requirements
- R1: While reset is asserted (`rst_n` low), all match flags, all pending flags, `rd_valid_o`, `undef_o` and `rd_data_o` are 0.
- R2: A pulse on `match_i[k]` while `paused_i` is 0 sets match flag k on the next edge. The flag then stays 1 until an accepted write changes it.
- R3: A pulse on `match_i[k]` while `paused_i` is 1 sets pending flag k and leaves match flag k unchanged. Pending flag k also holds until an accepted write changes it.
- R4: A write is accepted only when `tu_state_i` is 2'b00 (idle). An accepted write loads match flag n from `wr_data_i[31]` and pending flag n from `wr_data_i[30]`.
- R5: When a match pulse and an accepted write hit the same unit in the same cycle, the match wins. With `paused_i` 0 the match flag ends at 1; with `paused_i` 1 the pending flag ends at 1.
- R6: A write presented while `tu_state_i` is 2'b01 (stable), 2'b10 (running) or 2'b11 changes no flag.
- R7: Read word layout. Bit 31 is the match flag and bit 30 is the pending flag. Bit 3 is `PCMP_MASK[n]`. Bit 0 is 1. Bits 2 and 1 are 0, as are bits 63:32 and 29:4.
- R8: A read of an implemented index returns `rd_valid_o`=1 and the word on the next cycle, but only when `tu_state_i` was 2'b00 or 2'b01 at the access. Otherwise `rd_valid_o` is 0 and `rd_data_o` is all zero. The returned word holds the flags as they stood before that edge.
- R9: The index n is `acc_crm_i[2:0]`, and it is valid only when `acc_crm_i[3]` is 1 and n < NUM_UNITS. An access with an invalid index raises `undef_o` on the next cycle, gives no read data and changes no flag.
- R10: `match_o` and `pending_o` always show the current match and pending flags of every unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| match_i | input | NUM_UNITS | Fire pulse, one per unit |
| paused_i | input | 1 | Resources are in the paused state |
| tu_state_i | input | 2 | Trace unit state: 00 idle, 01 stable, 10/11 running |
| acc_valid_i | input | 1 | Software access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_crm_i | input | 4 | CRm field of the register encoding |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Read word, one cycle after the access |
| rd_valid_o | output | 1 | Read word is valid |
| undef_o | output | 1 | Previous access named an unimplemented index |
| match_o | output | NUM_UNITS | Match flag of each unit |
| pending_o | output | NUM_UNITS | Pending flag of each unit |

## Verification
The flags are exported directly, so a wrong flag shows on `match_o` or `pending_o` on the edge after the event that caused it. A lost or spurious match, a missed pause, or a write that was wrongly accepted or wrongly dropped all appear there. The same fault shows one cycle later in the read word, along with any mistake in index decoding or in the per-unit capability bit. A response that is too permissive or too strict for the trace unit state appears as a wrong `rd_valid_o` or `undef_o` on the cycle after the access.

// File: rtl/sscmp_status_bank.sv
module sscmp_status_bank #(
  parameter int         NUM_UNITS = 8,
  parameter logic [7:0] PCMP_MASK = 8'h00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] match_i,
  input  logic                 paused_i,
  input  logic [1:0]           tu_state_i,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic [3:0]           acc_crm_i,
  input  logic [63:0]          wr_data_i,
  output logic [63:0]          rd_data_o,
  output logic                 rd_valid_o,
  output logic                 undef_o,
  output logic [NUM_UNITS-1:0] match_o,
  output logic [NUM_UNITS-1:0] pending_o
);
  localparam int MAXU = 8;

  logic [NUM_UNITS-1:0] stat_q, pend_q;
  logic [MAXU-1:0]      stat_pad, pend_pad;
  logic [2:0]           idx;
  logic                 idx_ok, is_idle, rd_ok, wr_en, rd_en;
  logic [63:0]          word;

  assign idx     = acc_crm_i[2:0];
  assign idx_ok  = acc_crm_i[3] && (int'(idx) < NUM_UNITS);
  assign is_idle = (tu_state_i == 2'b00);
  assign rd_ok   = is_idle || (tu_state_i == 2'b01);
  assign wr_en   = acc_valid_i && acc_write_i && idx_ok && is_idle;
  assign rd_en   = acc_valid_i && !acc_write_i && idx_ok && rd_ok;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    logic wr_hit;
    assign wr_hit = wr_en && (idx == 3'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        stat_q[i] <= 1'b0;
      else if (match_i[i] && !paused_i)  stat_q[i] <= 1'b1;
      else if (wr_hit)                   stat_q[i] <= wr_data_i[31];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        pend_q[i] <= 1'b0;
      else if (match_i[i] && paused_i)   pend_q[i] <= 1'b1;
      else if (wr_hit)                   pend_q[i] <= wr_data_i[30];
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[i] && !wr_hit |=> stat_q[i]); // R2
    AST_PEND_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      match_i[i] && paused_i |=> pend_q[i]); // R3
    AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      match_i[i] && !paused_i && wr_hit |=> stat_q[i]); // R5
    AST_BUSY_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_i && acc_write_i && !is_idle && !match_i[i]
      |=> $stable(stat_q[i]) && $stable(pend_q[i])); // R6
  end

  always_comb begin
    stat_pad = '0;
    pend_pad = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      stat_pad[i] = stat_q[i];
      pend_pad[i] = pend_q[i];
    end
    word      = '0;
    word[31]  = stat_pad[idx];
    word[30]  = pend_pad[idx];
    word[3]   = PCMP_MASK[idx];
    word[0]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      undef_o    <= 1'b0;
    end else begin
      rd_valid_o <= rd_en;
      rd_data_o  <= rd_en ? word : 64'd0;
      undef_o    <= acc_valid_i && !idx_ok;
    end
  end

  assign match_o   = stat_q;
  assign pending_o = pend_q;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[63:32] == 32'd0 && rd_data_o[29:4] == 26'd0 && rd_data_o[2:1] == 2'd0); // R7
  AST_INST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[0] == rd_valid_o); // R7
  AST_READ_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_ok)); // R8
  AST_UNDEF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid_o && undef_o)); // R9
endmodule

// File: tb/sscmp_status_bank_tb.sv
module sscmp_status_bank_tb;
  localparam int         NU  = 6;
  localparam logic [7:0] PCM = 8'b0010_1001;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NU-1:0] match_i = '0;
  logic          paused_i = 1'b0;
  logic [1:0]    tu_state_i = 2'b00;
  logic          acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [3:0]    acc_crm_i = 4'h8;
  logic [63:0]   wr_data_i = '0;
  logic [63:0]   rd_data_o;
  logic          rd_valid_o, undef_o;
  logic [NU-1:0] match_o, pending_o;

  sscmp_status_bank #(.NUM_UNITS(NU), .PCMP_MASK(PCM)) u_dut (
    .clk(clk), .rst_n(rst_n), .match_i(match_i), .paused_i(paused_i),
    .tu_state_i(tu_state_i), .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
    .acc_crm_i(acc_crm_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .undef_o(undef_o), .match_o(match_o), .pending_o(pending_o));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  logic [NU-1:0] m_st = '0, m_pd = '0;
  logic [63:0]   e_data;
  logic          e_valid, e_undef;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_word(int n, logic s, logic p);
    logic [63:0] w = '0;
    w[31] = s; w[30] = p; w[3] = PCM[n]; w[0] = 1'b1;
    return w;
  endfunction

  function automatic bit idx_valid(logic [3:0] crm);
    return crm[3] && (int'(crm[2:0]) < NU);
  endfunction

  // advance one edge, update the model, compare every output
  task automatic step();
    int n = int'(acc_crm_i[2:0]);
    bit ok = idx_valid(acc_crm_i);
    bit rdok = (tu_state_i == 2'b00) || (tu_state_i == 2'b01);
    e_valid = acc_valid_i && !acc_write_i && ok && rdok;
    e_undef = acc_valid_i && !ok;
    e_data  = e_valid ? exp_word(n, m_st[n], m_pd[n]) : 64'd0;
    if (acc_valid_i && acc_write_i && ok && tu_state_i == 2'b00) begin
      m_st[n] = wr_data_i[31];
      m_pd[n] = wr_data_i[30];
    end
    for (int k = 0; k < NU; k++) begin
      if (match_i[k] && !paused_i) m_st[k] = 1'b1;
      if (match_i[k] &&  paused_i) m_pd[k] = 1'b1;
    end
    @(posedge clk); #1;
    check("R2 match_o", 64'(match_o), 64'(m_st));
    check("R3 pending_o", 64'(pending_o), 64'(m_pd));
    check("R8 rd_valid_o", 64'(rd_valid_o), 64'(e_valid));
    check("R9 undef_o", 64'(undef_o), 64'(e_undef));
    check("R7 rd_data_o", rd_data_o, e_data);
  endtask

  task automatic drive(logic [NU-1:0] m, logic p, logic [1:0] st, logic v,
                       logic w, logic [3:0] crm, logic [63:0] d);
    match_i = m; paused_i = p; tu_state_i = st; acc_valid_i = v;
    acc_write_i = w; acc_crm_i = crm; wr_data_i = d;
    step();
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 match_o", 64'(match_o), 0);
    check("R1 pending_o", 64'(pending_o), 0);
    check("R1 rd_valid_o", 64'(rd_valid_o), 0);
    check("R1 undef_o", 64'(undef_o), 0);
    check("R1 rd_data_o", rd_data_o, 0);
    rst_n = 1'b1;

    // R2: match sets a sticky flag, visible through the read
    drive(6'b000100, 0, 2'b00, 0, 0, 4'h8, 0);
    drive(6'b000000, 0, 2'b01, 1, 0, 4'hA, 0);
    check("R8 read in stable", rd_data_o, exp_word(2, 1, 0));
    // R10: exported flags
    check("R10 match_o bit", 64'(match_o[2]), 1);
    // R4: clear by write in idle
    drive(0, 0, 2'b00, 1, 1, 4'hA, 64'h0);
    check("R4 write clears", 64'(match_o[2]), 0);
    // R5: match and write collide
    drive(6'b000100, 0, 2'b00, 1, 1, 4'hA, 64'h0);
    check("R5 match wins", 64'(match_o[2]), 1);
    drive(6'b000100, 1, 2'b00, 1, 1, 4'hA, 64'h0);
    check("R5 pending wins", 64'(pending_o[2]), 1);
    // R3: paused match only touches pending
    drive(6'b010000, 1, 2'b00, 0, 0, 4'h8, 0);
    check("R3 pending set", 64'(pending_o[4]), 1);
    check("R3 match untouched", 64'(match_o[4]), 0);
    // R6: write while running is dropped
    drive(0, 0, 2'b10, 1, 1, 4'hC, 64'hC000_0000);
    check("R6 running write", 64'(pending_o[4]), 1);
    check("R6 running write st", 64'(match_o[4]), 0);
    drive(0, 0, 2'b01, 1, 1, 4'hC, 64'h0);
    check("R6 stable write", 64'(pending_o[4]), 1);
    // R4: write sets both flags
    drive(0, 0, 2'b00, 1, 1, 4'h9, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R4 write sets", 64'({match_o[1], pending_o[1]}), 2'b11);
    // R8: read in running
    drive(0, 0, 2'b10, 1, 0, 4'h9, 0);
    check("R8 running read", 64'(rd_valid_o), 0);
    // R9: malformed and unimplemented index
    drive(0, 0, 2'b00, 1, 0, 4'h1, 0);
    check("R9 crm bit3 low", 64'(undef_o), 1);
    drive(0, 0, 2'b00, 1, 1, 4'hE, 64'hC000_0000);
    check("R9 idx 6 undef", 64'(undef_o), 1);
    drive(0, 0, 2'b00, 1, 1, 4'h6, 64'hC000_0000);
    check("R9 no state change", 64'({match_o, pending_o}), 64'({m_st, m_pd}));
    // R7: capability bit per unit
    for (int k = 0; k < NU; k++) begin
      drive(0, 0, 2'b00, 1, 0, 4'(8 + k), 0);
      check("R7 cap bit3", 64'(rd_data_o[3]), 64'(PCM[k]));
    end

    // constrained random
    for (int c = 0; c < 3000; c++) begin
      logic [NU-1:0] m = '0;
      for (int k = 0; k < NU; k++) m[k] = ($urandom_range(0, 7) == 0);
      drive(m, $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3) == 0 ? $urandom_range(1, 3) : 0),
            $urandom_range(0, 1), $urandom_range(0, 2) == 0,
            4'($urandom_range(0, 4) == 0 ? $urandom_range(0, 15) : 8 + $urandom_range(0, NU - 1)),
            {$urandom, $urandom});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule